// File: doc/BRIEF.md
# Bitplane Framebuffer Access Sequencer

This block sits between a set of identical byte-wide SRAM bitplanes, a display scan and a processor whose clock is unrelated to the pixel clock. All planes share one address bus. Time is cut into memory slots of eight pixel clocks. In each slot the display fetch comes first: one byte per plane is read from the address supplied by the scan timing logic and loaded into that plane's pixel shifter. The shifter then sends one bit per pixel clock.

The last five clocks of each slot belong to the processor. A processor read fetches the byte from every plane, and a plane-select register chooses which one is returned. A processor write does not carry pixel data. The written byte is a pixel mask, and every plane takes a read-modify-write in the same window: masked pixels take that plane's bit of a colour register, and the other pixels keep their old value. A wait output holds the processor until its access is finished. The colour and plane-select registers are loaded through a small configuration port in the pixel clock domain.

Top module: `bitplane_seq`

## Requirements
- R1: A slot is 8 pixel clocks, phases 0 to 7. Phase 0 is the first clock after reset is released. During phases 0 to 2, `sram_oe` is high and `sram_addr` holds the `disp_addr` value sampled at the clock edge that starts phase 0.
- R2: At the edge that ends phase 2, each plane loads its `sram_rdata` byte (plane p in bits p*8+7 down to p*8) into its shifter. `pix_out[p]` gives bit 7 during phase 3 and bit 0 during phase 2 of the next slot, one bit per clock, most significant first.
- R3: A processor access uses phases 3 to 7 at the processor address. The old bytes are read during phases 3 to 5. `sram_we` is high only during phases 6 and 7, at that same address. `sram_we` and `sram_oe` are never high together.
- R4: A write makes each plane p hold new = (old AND NOT mask) OR (mask AND eight copies of colour bit p), where mask is `cpu_wdata`. A mask of 0x00 leaves the byte unchanged, and a mask of 0xFF fills it with the colour bit.
- R5: One processor write updates every plane at the same address in the same access.
- R6: A processor read returns the byte of plane `plane_select` when that value is below NPLANES, and 0x00 for the values NPLANES and up.
- R7: `cpu_wait` goes high as soon as `cpu_req` rises and falls once the access has completed, at most 24 pixel clocks later. After `cpu_req` is dropped, `cpu_wait` stays high until the block has seen the drop, and then goes low. A request that is seen after the start decision at the end of phase 2 waits for the next slot.
- R8: The configuration port with `cfg_we` high writes the colour register (the low NPLANES bits of `cfg_wdata`) when `cfg_sel` is 0, and writes the plane select (the low 3 bits) when `cfg_sel` is 1. Configuration writes leave the SRAM contents unchanged.
- R9: While reset is held, `pix_out` is all zero, `sram_we` is low, `cpu_rdata` is 0, and `cpu_wait` is low when `cpu_req` is low.
- R10: A processor write leaves `cpu_rdata` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_addr | input | AW | Display fetch address from the scan timing logic |
| pix_out | output | NPLANES | Serial pixel bit per plane |
| cpu_req | input | 1 | Processor access request level (asynchronous) |
| cpu_we | input | 1 | 1 = mask write, 0 = read |
| cpu_addr | input | AW | Processor byte address, common to all planes |
| cpu_wdata | input | DW | Pixel mask for writes |
| cpu_rdata | output | DW | Byte from the selected plane |
| cpu_wait | output | 1 | Wait state toward the processor |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = colour register, 1 = plane select |
| cfg_wdata | input | NPLANES | Configuration write data |
| sram_addr | output | AW | Shared SRAM address |
| sram_oe | output | 1 | SRAM output enable |
| sram_we | output | 1 | SRAM write enable, common to all planes |
| sram_wdata | output | NPLANES*DW | Write bytes, plane p in bits p*DW+DW-1 down to p*DW |
| sram_rdata | input | NPLANES*DW | Read bytes, same packing |

## Verification
The case that is hardest to reach from the ports is where an asynchronous request lands relative to the start decision at the end of phase 2. The synchroniser delay decides whether the access runs in the current window or slips a whole slot, and a write must still hit the memory only in phases 6 and 7. The bench counts clocks from the release of reset, which fixes the slot phase. It then raises requests on each of the eight phases in turn, for both reads and mask writes. During this sweep it monitors the write strobe, the address and the wait latency, and it reads every plane back to check the merged bytes.

// File: rtl/bitplane_pkg.sv
package bitplane_pkg;

  // configuration register selector
  typedef enum logic {
    CFG_COLOUR = 1'b0,
    CFG_PSEL   = 1'b1
  } cfg_sel_e;

  // processor access kind currently held in the window
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_READ = 2'd1,
    SQ_RMW  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/bitplane_slot_timer.sv
module bitplane_slot_timer #(
  parameter int SLOT = 8,
  localparam int PHW = $clog2(SLOT)
) (
  input  logic           clk,
  input  logic           rst,
  output logic [PHW-1:0] ph
);

  localparam logic [PHW-1:0] PH_LAST = PHW'(SLOT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0;
    end else if (ph == PH_LAST) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LAST) |=> (ph == '0)); // R1

endmodule

// File: rtl/bitplane_sync.sv
module bitplane_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], d};
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/bitplane_lane.sv
module bitplane_lane #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] rd_byte,
  input  logic [DW-1:0] mask,
  input  logic          colour_bit,
  output logic [DW-1:0] wr_byte,
  output logic          pix
);

  logic [DW-1:0] shreg;

  // masked pixels take the colour bit, the rest keep the stored value
  always_comb begin
    wr_byte = (rd_byte & ~mask) | (mask & {DW{colour_bit}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg <= '0;
    end else if (load) begin
      shreg <= rd_byte;
    end else begin
      shreg <= {shreg[DW-2:0], 1'b0};
    end
  end

  assign pix = shreg[DW-1];

  AST_LOAD_MSB_FIRST: assert property (@(posedge clk) disable iff (rst)
    load |=> (pix == $past(rd_byte[DW-1]))); // R2

endmodule

// File: rtl/bitplane_seq.sv
module bitplane_seq
  import bitplane_pkg::*;
#(
  parameter int NPLANES     = 6,
  parameter int AW          = 17,
  parameter int DW          = 8,
  parameter int DISP_CLKS   = 3,
  parameter int RD_CLKS     = 3,
  parameter int WR_CLKS     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         disp_addr,
  output logic [NPLANES-1:0]    pix_out,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic [AW-1:0]         cpu_addr,
  input  logic [DW-1:0]         cpu_wdata,
  output logic [DW-1:0]         cpu_rdata,
  output logic                  cpu_wait,
  input  logic                  cfg_we,
  input  logic                  cfg_sel,
  input  logic [NPLANES-1:0]    cfg_wdata,
  output logic [AW-1:0]         sram_addr,
  output logic                  sram_oe,
  output logic                  sram_we,
  output logic [NPLANES*DW-1:0] sram_wdata,
  input  logic [NPLANES*DW-1:0] sram_rdata
);

  localparam int SLOT = DISP_CLKS + RD_CLKS + WR_CLKS;
  localparam int PHW  = $clog2(SLOT);
  localparam int PSW  = $clog2(NPLANES + 1);
  localparam logic [PHW-1:0] PH_START = PHW'(DISP_CLKS - 1);
  localparam logic [PHW-1:0] PH_HOLD  = PHW'(DISP_CLKS);
  localparam logic [PHW-1:0] PH_CAP   = PHW'(DISP_CLKS + RD_CLKS - 1);
  localparam logic [PHW-1:0] PH_LAST  = PHW'(SLOT - 1);
  localparam logic [PHW-1:0] PH_DISP  = PHW'(DISP_CLKS);

  logic [PHW-1:0]        ph;
  logic                  req_s;
  logic                  ack_q;
  seq_state_e            st;
  logic [NPLANES-1:0]    colour_q;
  logic [PSW-1:0]        psel_q;
  logic [DW-1:0]         mask_q;
  logic [DW-1:0]         rd_q [NPLANES];
  logic [DW-1:0]         sel_byte;
  logic [NPLANES*DW-1:0] merged;
  logic                  disp_load;
  cfg_sel_e              cfg_kind;

  // ---------------------------------------------------------------- timing
  bitplane_slot_timer #(.SLOT(SLOT)) u_timer (
    .clk (clk),
    .rst (rst),
    .ph  (ph)
  );

  bitplane_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (cpu_req),
    .q   (req_s)
  );

  assign disp_load = (ph == PH_START);

  // ---------------------------------------------------------- config port
  assign cfg_kind = cfg_sel_e'(cfg_sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      colour_q <= '0;
      psel_q   <= '0;
    end else if (cfg_we) begin
      if (cfg_kind == CFG_COLOUR) begin
        colour_q <= cfg_wdata;
      end else begin
        psel_q <= cfg_wdata[PSW-1:0];
      end
    end
  end

  // ---------------------------------------------------------------- lanes
  for (genvar p = 0; p < NPLANES; p++) begin : g_lane
    bitplane_lane #(.DW(DW)) u_lane (
      .clk        (clk),
      .rst        (rst),
      .load       (disp_load),
      .rd_byte    (sram_rdata[p*DW +: DW]),
      .mask       (mask_q),
      .colour_bit (colour_q[p]),
      .wr_byte    (merged[p*DW +: DW]),
      .pix        (pix_out[p])
    );
  end

  // plane selection for reads, zero when out of range
  always_comb begin
    sel_byte = '0;
    for (int p = 0; p < NPLANES; p++) begin
      if (psel_q == PSW'(p)) begin
        sel_byte = rd_q[p];
      end
    end
  end

  // ------------------------------------------------------------ sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      ack_q      <= 1'b0;
      sram_addr  <= '0;
      sram_oe    <= 1'b1;
      sram_we    <= 1'b0;
      sram_wdata <= '0;
      mask_q     <= '0;
      cpu_rdata  <= '0;
      for (int p = 0; p < NPLANES; p++) begin
        rd_q[p] <= '0;
      end
    end else begin
      if (!req_s && ack_q) begin
        ack_q <= 1'b0;
      end
      if (ph == PH_LAST) begin
        // next slot opens with the display fetch
        sram_addr <= disp_addr;
        sram_oe   <= 1'b1;
        sram_we   <= 1'b0;
        if (st != SQ_IDLE) begin
          ack_q <= 1'b1;
          if (st == SQ_READ) begin
            cpu_rdata <= sel_byte;
          end
          st <= SQ_IDLE;
        end
      end else if (ph == PH_START) begin
        if (req_s && !ack_q) begin
          st        <= cpu_we ? SQ_RMW : SQ_READ;
          sram_addr <= cpu_addr;
          mask_q    <= cpu_wdata;
          sram_oe   <= 1'b1;
        end else begin
          sram_oe <= 1'b0;
        end
      end else if (ph == PH_CAP) begin
        sram_oe <= 1'b0;
        if (st != SQ_IDLE) begin
          for (int p = 0; p < NPLANES; p++) begin
            rd_q[p] <= sram_rdata[p*DW +: DW];
          end
        end
        if (st == SQ_RMW) begin
          sram_we    <= 1'b1;
          sram_wdata <= merged;
        end
      end
    end
  end

  // wait follows the request edge at once, and clears on the handshake
  assign cpu_wait = cpu_req ? ~ack_q : ack_q;

  // ----------------------------------------------------------- assertions
  AST_DISP_OE: assert property (@(posedge clk) disable iff (rst)
    (ph < PH_DISP) |-> sram_oe); // R1

  AST_WE_WINDOW: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> (ph > PH_CAP)); // R3

  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sram_we && sram_oe)); // R3

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    ((st != SQ_IDLE) && (ph > PH_HOLD)) |-> $stable(sram_addr)); // R3

  AST_ACK_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_q) |-> ($past(ph) == PH_LAST)); // R7

  AST_RDATA_ON_READ: assert property (@(posedge clk) disable iff (rst)
    !$stable(cpu_rdata) |-> ((ph == '0) && ($past(st) == SQ_READ))); // R10

endmodule

// File: tb/bitplane_seq_bench.sv
module bitplane_seq_bench;

  localparam int NP = 6;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [AW-1:0]     disp_addr = '0;
  logic [NP-1:0]     pix_out;
  logic              cpu_req = 1'b0;
  logic              cpu_we = 1'b0;
  logic [AW-1:0]     cpu_addr = '0;
  logic [DW-1:0]     cpu_wdata = '0;
  logic [DW-1:0]     cpu_rdata;
  logic              cpu_wait;
  logic              cfg_we = 1'b0;
  logic              cfg_sel = 1'b0;
  logic [NP-1:0]     cfg_wdata = '0;
  logic [AW-1:0]     sram_addr;
  logic              sram_oe;
  logic              sram_we;
  logic [NP*DW-1:0]  sram_wdata;
  logic [NP*DW-1:0]  sram_rdata;

  logic [DW-1:0] mem     [NP][DEPTH];
  logic [DW-1:0] exp_mem [NP][DEPTH];
  logic [DW-1:0] exp_q [$];

  int n_chk = 0;
  int n_err = 0;
  int cnt = 0;
  int we_phase_bad = 0;
  int we_addr_bad = 0;
  int we_oe_bad = 0;
  logic [AW-1:0] cur_addr = '0;
  logic [NP-1:0] colour_sh = '0;
  int psel_sh = 0;

  always #10 clk = ~clk;

  bitplane_seq #(.NPLANES(NP), .AW(AW), .DW(DW)) u_bitplane_seq (
    .clk        (clk),
    .rst        (rst),
    .disp_addr  (disp_addr),
    .pix_out    (pix_out),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .cpu_wait   (cpu_wait),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .sram_addr  (sram_addr),
    .sram_oe    (sram_oe),
    .sram_we    (sram_we),
    .sram_wdata (sram_wdata),
    .sram_rdata (sram_rdata)
  );

  // SRAM model: asynchronous read, write on the clock while enabled
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      sram_rdata[p*DW +: DW] = mem[p][sram_addr];
    end
  end

  always @(posedge clk) begin
    if (sram_we) begin
      for (int p = 0; p < NP; p++) begin
        mem[p][sram_addr] <= sram_wdata[p*DW +: DW];
      end
    end
  end

  // clocks since reset release; the slot phase is cnt mod 8 (R1)
  always @(posedge clk) begin
    if (rst) cnt <= 0;
    else     cnt <= cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read bytes when an access completes
  logic prev_wait = 1'b0;
  always begin
    @(posedge clk);
    #5;
    if (!rst) begin
      if (sram_we && !((cnt % 8) == 6 || (cnt % 8) == 7)) we_phase_bad++;
      if (sram_we && sram_addr != cur_addr) we_addr_bad++;
      if (sram_we && sram_oe) we_oe_bad++;
      if (cpu_req && prev_wait && !cpu_wait && !cpu_we) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected read completion", cpu_rdata, 0);
        end else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          check(cpu_rdata == e, "R6 read data", cpu_rdata, e);
        end
      end
    end
    prev_wait = cpu_wait;
  end

  task automatic wait_phase(input int ph);
    do @(negedge clk); while ((cnt % 8) != ph);
  endtask

  task automatic cfg_write(input bit sel, input logic [NP-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_sel = sel;
    cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) psel_sh = int'(val[2:0]);
    else     colour_sh = val;
  endtask

  task automatic cpu_access(input bit we, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, input int start_ph);
    logic [DW-1:0] rd_before;
    int lat;
    wait_phase(start_ph);
    cpu_we = we;
    cpu_addr = a;
    cpu_wdata = d;
    cur_addr = a;
    if (we) begin
      for (int p = 0; p < NP; p++) begin
        exp_mem[p][a] = (exp_mem[p][a] & ~d) | (d & {DW{colour_sh[p]}});
      end
    end else begin
      exp_q.push_back((psel_sh < NP) ? exp_mem[psel_sh][a] : 8'h00);
    end
    rd_before = cpu_rdata;
    cpu_req = 1'b1;
    #1;
    check(cpu_wait == 1'b1, "R7 wait rises with request", cpu_wait, 1);
    lat = 0;
    while (cpu_wait) begin
      @(negedge clk);
      lat++;
    end
    check(lat <= 24, "R7 access latency", lat, 24);
    if (we) check(cpu_rdata == rd_before, "R10 write keeps read data", cpu_rdata, rd_before);
    cpu_req = 1'b0;
    #1;
    check(cpu_wait == 1'b1, "R7 wait held until request drop seen", cpu_wait, 1);
    while (cpu_wait) @(negedge clk);
  endtask

  task automatic read_all_planes(input logic [AW-1:0] a, input int start_ph);
    for (int p = 0; p < NP; p++) begin
      cfg_write(1'b1, NP'(p));
      cpu_access(1'b0, a, 8'h00, (start_ph + p) % 8);
    end
  endtask

  task automatic check_pix(input logic [AW-1:0] a, input string tag);
    logic [DW-1:0] got [NP];
    @(negedge clk);
    disp_addr = a;
    repeat (20) @(negedge clk);
    wait_phase(3);
    for (int i = 0; i < DW; i++) begin
      for (int p = 0; p < NP; p++) got[p][DW-1-i] = pix_out[p];
      if (i < DW - 1) @(negedge clk);
    end
    for (int p = 0; p < NP; p++) begin
      check(got[p] == exp_mem[p][a], tag, got[p], exp_mem[p][a]);
    end
  endtask

  // watchdog: a hung run counts as a failure
  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      for (int a = 0; a < DEPTH; a++) begin
        mem[p][a]     = 8'((p * 53 + a * 7 + 11) ^ (a >> 1));
        exp_mem[p][a] = 8'((p * 53 + a * 7 + 11) ^ (a >> 1));
      end
    end
    repeat (4) @(negedge clk);
    // R9 reset state
    check(pix_out == '0, "R9 pixels during reset", pix_out, 0);
    check(sram_we == 1'b0, "R9 write strobe during reset", sram_we, 0);
    check(cpu_rdata == '0, "R9 read data during reset", cpu_rdata, 0);
    check(cpu_wait == 1'b0, "R9 wait during reset", cpu_wait, 0);
    rst = 1'b0;

    // R1 R2: display fetch and serial order
    check_pix(8'd5, "R2 display byte at 5");
    check_pix(8'd77, "R1 display byte at 77");

    // R6: plane select, including out-of-range values 6 and 7
    for (int s = 0; s < 8; s++) begin
      cfg_write(1'b1, NP'(s));
      cpu_access(1'b0, 8'd9, 8'h00, s);
    end

    // R4 R5: mask write touches every plane
    cfg_write(1'b0, 6'b101101);
    cpu_access(1'b1, 8'd9, 8'hF0, 3);
    read_all_planes(8'd9, 0);

    // R3 R7: requests launched on every slot phase
    for (int s = 0; s < 8; s++) begin
      cfg_write(1'b0, NP'((s * 9 + 5) & 63));
      cpu_access(1'b1, AW'(20 + s), 8'h5A ^ 8'(s * 17), s);
      cfg_write(1'b1, NP'(s % NP));
      cpu_access(1'b0, AW'(20 + s), 8'h00, (s + 5) % 8);
    end
    read_all_planes(8'd23, 2);

    // R4 mask corner cases
    cfg_write(1'b0, 6'b111111);
    cpu_access(1'b1, 8'd40, 8'h00, 6);
    read_all_planes(8'd40, 1);
    cfg_write(1'b0, 6'b101010);
    cpu_access(1'b1, 8'd41, 8'hFF, 2);
    read_all_planes(8'd41, 4);

    // R2 merged bytes visible on the display
    check_pix(8'd9, "R2 display after write at 9");
    check_pix(8'd41, "R4 display after full mask at 41");

    // R8 configuration writes leave memory alone
    cfg_write(1'b0, 6'b010101);
    cfg_write(1'b1, 6'd3);
    check_pix(8'd5, "R8 display unchanged after config writes");
    cpu_access(1'b0, 8'd41, 8'h00, 0);

    repeat (20) @(negedge clk);
    check(we_phase_bad == 0, "R3 write strobe outside phases 6-7", we_phase_bad, 0);
    check(we_addr_bad == 0, "R3 write address differs from access", we_addr_bad, 0);
    check(we_oe_bad == 0, "R3 write and output enable together", we_oe_bad, 0);
    check(exp_q.size() == 0, "R6 reads left unanswered", exp_q.size(), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule